// File: doc/BRIEF.md
# Block-Addressed SPI Register Target

This block is the device side of a mode-0 SPI link. A system clock that runs well above the serial clock samples SCK, CS_N and MOSI through synchronizers and drives MISO. Each chip-select frame opens with a three-byte header. The header carries a 16-bit offset, high byte first, and then a control byte. The block is chosen by the control byte and not by the offset, so the offset only locates a byte inside the chosen block. Any number of payload bytes may follow the header. The frame ends only when chip select returns high.

Four storage blocks sit behind the decoder:
- a common register block, which holds a mode register and a big-endian hardware address field starting at offset 0x09;
- a channel register block, which holds an interrupt register and an interrupt mask register;
- a transmit buffer;
- a receive buffer.

Writes store each payload byte at successive offsets. Reads return the stored bytes MSB-first, starting in the first data slot after the control byte. The interrupt register drives an active-low interrupt output. A bit in it is cleared by writing a one, and the mode register can issue a soft reset.

Top module: `spi_blk_target`

## Requirements
- R1: After reset, and whenever chip select is high, MISO is 0. After reset irq_n is 1.
- R2: A write frame stores payload byte i at header offset + i, and a read frame returns those bytes in order. Bytes move MSB-first, and the offset is sent high byte first.
- R3: Control bits [7:3] select the block: 0 common (16 bytes), 1 channel (64 bytes), 2 transmit buffer (32 bytes), 3 receive buffer (32 bytes). The same offset in different blocks addresses independent storage.
- R4: Control bit 2 gives the direction (1 write, 0 read). In a read frame the filler bytes sent by the master are not stored. The first response byte is shifted out in the data slot right after the control byte.
- R5: The offset advances by one after every data byte and wraps to 0 after the last byte of the block.
- R6: A read of a block number of 4 or above, or of an offset at or beyond the block size, returns 0x00. A write to either is ignored.
- R7: Only control bits [1:0] = 00 (variable-length mode) move data. With any other value, writes are ignored and reads return 0x00.
- R8: Every byte written into the receive buffer sets bit 2 of channel offset 0x02. irq_n is low while a bit is set both there and in the mask at channel offset 0x2C.
- R9: Writing 1 to bit 2 of channel offset 0x02 clears that bit, and irq_n is then released. Writing 0 there leaves the register unchanged.
- R10: Writing a byte with bit 7 set to common offset 0 clears every byte of the common and channel blocks, including the mode register itself. Buffer contents are kept.
- R11: If chip select rises in the middle of a byte, the partial byte is dropped and the next frame decodes its header from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The main path is driven with these patterns:
- a multi-byte write and read-back of the big-endian address field, which separates correct offset stepping and bit order from a swapped or stalled offset;
- single bytes at one offset in each block, which catch a decoder that ignores the block field;
- a burst that starts on the last buffer byte, which shows the wrap;
- frames to missing blocks, to out-of-range offsets and with non-zero mode bits, which must leave storage untouched.

Interrupt set, mask, clear and soft reset are checked at irq_n and by read-back. Frames cut after a partial header or a partial data byte show that no stray write survives and that the next frame decodes cleanly.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  localparam int BLK_W   = 5;
  localparam int NUM_BLK = 4;
  localparam int BLK_CMN = 0;
  localparam int BLK_CHN = 1;
  localparam int BLK_TXB = 2;
  localparam int BLK_RXB = 3;
  localparam logic [1:0] MODE_VAR = 2'b00;
  localparam logic [7:0] IR_BIT   = 8'h04;

  typedef enum logic [1:0] {
    PH_OFS_HI,
    PH_OFS_LO,
    PH_CTRL,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_tgt_frame.sv
module spi_tgt_frame
  import spi_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             cs_s,
  input  logic             mosi_s,
  input  logic [7:0]       rd_data,
  input  logic             acc_ok,
  input  logic             at_end,
  output logic [BLK_W-1:0] acc_blk,
  output logic [15:0]      acc_ofs,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             miso
);
  logic             sck_q;
  logic [6:0]       sh_q, sh_d;
  logic [2:0]       cnt_q, cnt_d;
  phase_e           ph_q, ph_d;
  logic [15:0]      ofs_q, ofs_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             wr_q, wr_d;
  logic             mok_q, mok_d;
  logic [7:0]       tx_q, tx_d;
  logic             ld_q, ld_d;
  logic             rise, byte_done;
  logic [7:0]       byte_in;

  assign rise      = sck_s & ~sck_q;
  assign byte_in   = {sh_q, mosi_s};
  assign byte_done = rise & ~cs_s & (cnt_q == 3'd7);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    ofs_d = ofs_q;
    blk_d = blk_q;
    wr_d  = wr_q;
    mok_d = mok_q;
    tx_d  = tx_q;
    ld_d  = 1'b0;
    if (cs_s) begin
      cnt_d = 3'd0;
      ph_d  = PH_OFS_HI;
      tx_d  = 8'h00;
    end else begin
      if (rise) begin
        sh_d  = byte_in[6:0];
        cnt_d = cnt_q + 3'd1;
        if (!byte_done) tx_d = {tx_q[6:0], 1'b0};
      end
      if (ld_q) tx_d = mok_q ? rd_data : 8'h00;
      if (byte_done) begin
        unique case (ph_q)
          PH_OFS_HI: begin
            ofs_d[15:8] = byte_in;
            ph_d        = PH_OFS_LO;
          end
          PH_OFS_LO: begin
            ofs_d[7:0] = byte_in;
            ph_d       = PH_CTRL;
          end
          PH_CTRL: begin
            blk_d = byte_in[7:3];
            wr_d  = byte_in[2];
            mok_d = (byte_in[1:0] == MODE_VAR);
            ld_d  = ~byte_in[2];
            ph_d  = PH_DATA;
          end
          default: begin
            ofs_d = at_end ? 16'h0000 : ofs_q + 16'd1;
            ld_d  = ~wr_q;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
      ph_q  <= PH_OFS_HI;
      ofs_q <= '0;
      blk_q <= '0;
      wr_q  <= 1'b0;
      mok_q <= 1'b0;
      tx_q  <= '0;
      ld_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      ofs_q <= ofs_d;
      blk_q <= blk_d;
      wr_q  <= wr_d;
      mok_q <= mok_d;
      tx_q  <= tx_d;
      ld_q  <= ld_d;
    end
  end

  assign acc_blk = blk_q;
  assign acc_ofs = ofs_q;
  assign wr_en   = byte_done & (ph_q == PH_DATA) & wr_q & mok_q & acc_ok;
  assign wr_data = byte_in;
  assign miso    = tx_q[7] & (ph_q == PH_DATA) & ~wr_q & ~cs_s;

  // R1: MISO stays quiet while the frame is closed
  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso);
endmodule

// File: rtl/spi_tgt_store.sv
module spi_tgt_store
  import spi_tgt_pkg::*;
#(
  parameter int CMN_DEPTH = 16,
  parameter int CHN_DEPTH = 64,
  parameter int BUF_DEPTH = 32,
  parameter int IR_OFS    = 2,
  parameter int IMR_OFS   = 44,
  parameter int SRST_OFS  = 0,
  parameter int SRST_BIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk,
  input  logic [15:0]      ofs,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             acc_ok,
  output logic             at_end,
  output logic             irq_n
);
  localparam int unsigned DEPTH [NUM_BLK] = '{CMN_DEPTH, CHN_DEPTH, BUF_DEPTH, BUF_DEPTH};
  localparam int SELW = $clog2(NUM_BLK);

  logic [7:0]         rd_vec [NUM_BLK];
  logic [NUM_BLK-1:0] ok_vec, end_vec;
  logic [7:0]         ir_val, imr_val;
  logic               srst, rx_wr, blk_in;

  assign srst  = wr_en && (blk == BLK_W'(BLK_CMN)) && (ofs == 16'(SRST_OFS)) && wr_data[SRST_BIT];
  assign rx_wr = wr_en && (blk == BLK_W'(BLK_RXB));

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    localparam int unsigned D = DEPTH[b];
    localparam int AW = $clog2(D);
    localparam bit IS_REG = (b == BLK_CMN) || (b == BLK_CHN);
    logic [7:0] mem [D];
    logic       sel;

    assign sel = wr_en && (blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < int'(D); i++) mem[i] <= 8'h00;
      end else begin
        for (int i = 0; i < int'(D); i++) begin
          if (IS_REG && srst) begin
            mem[i] <= 8'h00;
          end else if ((b == BLK_CHN) && (i == IR_OFS)) begin
            if (rx_wr) mem[i] <= mem[i] | IR_BIT;
            else if (sel && (ofs == 16'(i))) mem[i] <= mem[i] & ~(wr_data & IR_BIT);
          end else if (sel && (ofs == 16'(i))) begin
            mem[i] <= wr_data;
          end
        end
      end
    end

    assign ok_vec[b]  = ofs < 16'(D);
    assign end_vec[b] = ofs == 16'(D - 1);
    assign rd_vec[b]  = ok_vec[b] ? mem[ofs[AW-1:0]] : 8'h00;

    if (b == BLK_CHN) begin : g_irq
      assign ir_val  = mem[IR_OFS];
      assign imr_val = mem[IMR_OFS];
    end
  end

  assign blk_in  = blk < BLK_W'(NUM_BLK);
  assign rd_data = blk_in ? rd_vec[blk[SELW-1:0]] : 8'h00;
  assign acc_ok  = blk_in & ok_vec[blk[SELW-1:0]];
  assign at_end  = blk_in & end_vec[blk[SELW-1:0]];
  assign irq_n   = ~|(ir_val & imr_val);

  // R6: the decoder never strobes a write outside implemented storage
  assert_wr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (blk_in && acc_ok));
  // R9: clearing the interrupt bit releases the interrupt line
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && blk == BLK_W'(BLK_CHN) && ofs == 16'(IR_OFS) && wr_data[2]) |=> irq_n);
  // R10: a soft reset drops every pending interrupt
  assert_softrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> irq_n);
endmodule

// File: rtl/spi_blk_target.sv
module spi_blk_target
  import spi_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMN_DEPTH   = 16,
  parameter int CHN_DEPTH   = 64,
  parameter int BUF_DEPTH   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic irq_n
);
  logic [2:0]       pins_s;
  logic [BLK_W-1:0] acc_blk;
  logic [15:0]      acc_ofs;
  logic             wr_en, acc_ok, at_end;
  logic [7:0]       wr_data, rd_data;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i({sck, cs_n, mosi}), .sync_o(pins_s)
  );

  spi_tgt_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[2]), .cs_s(pins_s[1]), .mosi_s(pins_s[0]),
    .rd_data(rd_data), .acc_ok(acc_ok), .at_end(at_end),
    .acc_blk(acc_blk), .acc_ofs(acc_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .miso(miso)
  );

  spi_tgt_store #(.CMN_DEPTH(CMN_DEPTH), .CHN_DEPTH(CHN_DEPTH), .BUF_DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .blk(acc_blk), .ofs(acc_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .acc_ok(acc_ok), .at_end(at_end), .irq_n(irq_n)
  );
endmodule

// File: tb/spi_blk_target_tb.sv
module spi_blk_target_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq_n;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0] wdat [64];
  logic [7:0] mdl [4][64];
  int unsigned dep [4] = '{16, 64, 32, 32};
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  spi_blk_target dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                        .mosi(mosi), .miso(miso), .irq_n(irq_n));

  task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] mk_ctrl(input int blk, input bit wr, input int mode);
    return {5'(blk), wr, 2'(mode)};
  endfunction

  function automatic logic [7:0] model_rd(input int blk, input int mode, input int ofs);
    if (mode != 0 || blk >= 4 || ofs >= int'(dep[blk])) return 8'h00;
    return mdl[blk][ofs];
  endfunction

  task automatic model_wr(input int blk, input int mode, input int ofs, input logic [7:0] d);
    if (mode != 0 || blk >= 4 || ofs >= int'(dep[blk])) return;
    if (blk == 0 && ofs == 0 && d[7]) begin
      for (int i = 0; i < 64; i++) begin mdl[0][i] = 8'h00; mdl[1][i] = 8'h00; end
    end else if (blk == 1 && ofs == 2) begin
      mdl[1][2] = mdl[1][2] & ~(d & 8'h04);
    end else begin
      mdl[blk][ofs] = d;
      if (blk == 3) mdl[1][2] = mdl[1][2] | 8'h04;
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(d[i], r[i]);
  endtask

  // driver: pushes model expectations, the monitor compares them
  task automatic frame(input logic [15:0] ofs, input logic [7:0] ctrl, input int n, input string tag);
    logic [7:0] r;
    int o, blk, mode;
    o = int'(ofs); blk = int'(ctrl[7:3]); mode = int'(ctrl[1:0]);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte(ofs[15:8], r);
    spi_byte(ofs[7:0], r);
    spi_byte(ctrl, r);
    for (int i = 0; i < n; i++) begin
      if (ctrl[2]) begin
        spi_byte(wdat[i], r);
        model_wr(blk, mode, o, wdat[i]);
      end else begin
        exp_q.push_back(model_rd(blk, mode, o));
        tag_q.push_back(tag);
        spi_byte(8'h00, r);
        act_q.push_back(r);
      end
      if (blk < 4 && o == int'(dep[blk]) - 1) o = 0;
      else o = (o + 1) & 16'hFFFF;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic raw_frame(input logic [31:0] bits, input int nb);
    logic r;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) spi_bit(bits[i], r);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  // monitor: compares each returned byte with the expectation
  initial begin
    forever begin
      @(posedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        chk(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int i = 0; i < 64; i++) mdl[b][i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({7'd0, miso}, 8'h00, "R1 miso idle");
    chk({7'd0, irq_n}, 8'h01, "R1 irq_n idle");

    // R2 big-endian hardware address burst and read-back
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    wdat[3] = 8'h44; wdat[4] = 8'h55; wdat[5] = 8'h66;
    frame(16'h0009, mk_ctrl(0, 1, 0), 6, "R2 write");
    frame(16'h0009, mk_ctrl(0, 0, 0), 6, "R2 readback");
    frame(16'h000E, mk_ctrl(0, 0, 0), 2, "R6 end of common block");

    // R3 block select: same offset, different blocks
    wdat[0] = 8'hA5;
    frame(16'h0005, mk_ctrl(2, 1, 0), 1, "R3 txbuf write");
    wdat[0] = 8'h5A;
    frame(16'h0005, mk_ctrl(3, 1, 0), 1, "R3 rxbuf write");
    frame(16'h0005, mk_ctrl(2, 0, 0), 1, "R3 txbuf read");
    frame(16'h0005, mk_ctrl(3, 0, 0), 1, "R3 rxbuf read");
    frame(16'h0005, mk_ctrl(0, 0, 0), 1, "R3 common read");
    // R4 read frames do not disturb storage
    frame(16'h0005, mk_ctrl(2, 0, 0), 1, "R4 reread");

    // R5 wrap at buffer end
    wdat[0] = 8'h01; wdat[1] = 8'h02; wdat[2] = 8'h03;
    frame(16'h001F, mk_ctrl(2, 1, 0), 3, "R5 wrap write");
    frame(16'h001F, mk_ctrl(2, 0, 0), 3, "R5 wrap read");
    frame(16'h0000, mk_ctrl(2, 0, 0), 1, "R5 wrapped byte");

    // R6 missing block and out-of-range offset
    wdat[0] = 8'hFF;
    frame(16'h0000, mk_ctrl(5, 1, 0), 1, "R6 bad block write");
    frame(16'h0000, mk_ctrl(5, 0, 0), 1, "R6 bad block read");
    frame(16'h0014, mk_ctrl(0, 1, 0), 1, "R6 bad offset write");
    frame(16'h0014, mk_ctrl(0, 0, 0), 1, "R6 bad offset read");

    // R7 non-zero mode bits
    wdat[0] = 8'h77;
    frame(16'h0001, mk_ctrl(0, 1, 1), 1, "R7 mode write");
    frame(16'h0001, mk_ctrl(0, 0, 0), 1, "R7 mode write ignored");
    frame(16'h0009, mk_ctrl(0, 0, 1), 1, "R7 mode read");

    // R8 interrupt set by receive buffer write, masked then unmasked
    repeat (4) @(negedge clk);
    chk({7'd0, irq_n}, 8'h01, "R8 masked irq_n");
    wdat[0] = 8'h04;
    frame(16'h002C, mk_ctrl(1, 1, 0), 1, "R8 mask write");
    chk({7'd0, irq_n}, 8'h00, "R8 unmasked irq_n");
    frame(16'h0002, mk_ctrl(1, 0, 0), 1, "R8 status read");

    // R9 write-one-to-clear
    wdat[0] = 8'h00;
    frame(16'h0002, mk_ctrl(1, 1, 0), 1, "R9 zero write");
    chk({7'd0, irq_n}, 8'h00, "R9 zero write keeps irq");
    wdat[0] = 8'h04;
    frame(16'h0002, mk_ctrl(1, 1, 0), 1, "R9 clear write");
    chk({7'd0, irq_n}, 8'h01, "R9 irq released");
    frame(16'h0002, mk_ctrl(1, 0, 0), 1, "R9 status after clear");

    // R11 chip select drops in a data byte, then inside the header
    raw_frame({16'h0003, mk_ctrl(0, 1, 0)[7:0], 8'hFF} >> 3, 29);
    frame(16'h0003, mk_ctrl(0, 0, 0), 1, "R11 partial byte dropped");
    raw_frame(32'h00000FFF, 12);
    wdat[0] = 8'h3C;
    frame(16'h0003, mk_ctrl(0, 1, 0), 1, "R11 clean frame write");
    frame(16'h0003, mk_ctrl(0, 0, 0), 2, "R11 clean frame read");

    // R10 soft reset
    wdat[0] = 8'h99;
    frame(16'h0000, mk_ctrl(3, 1, 0), 1, "R10 set irq");
    chk({7'd0, irq_n}, 8'h00, "R10 irq before reset");
    wdat[0] = 8'h80;
    frame(16'h0000, mk_ctrl(0, 1, 0), 1, "R10 reset write");
    chk({7'd0, irq_n}, 8'h01, "R10 irq after reset");
    frame(16'h0000, mk_ctrl(0, 0, 0), 1, "R10 mode reg cleared");
    frame(16'h0009, mk_ctrl(0, 0, 0), 2, "R10 common cleared");
    frame(16'h002C, mk_ctrl(1, 0, 0), 1, "R10 mask cleared");
    frame(16'h0005, mk_ctrl(2, 0, 0), 1, "R10 buffer kept");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule